// File: doc/BRIEF.md
# Wishbone Register Bank Slave

A slave for the Wishbone bus that holds a small, parameterised array of word-wide read/write registers. A master runs one single-word transfer at a time: it raises the cycle and strobe lines with an address, a write flag and write data. The slave answers with exactly one termination pulse. That pulse is a normal acknowledge for an address inside the bank, an error for an address past the last register, or a retry request when retry mode is enabled.

The block is also meant as a target for exercising masters. A configuration input sets how many cycles the stall line stays high while a request waits before it is taken. A second input makes the slave refuse each fresh request once with a retry before it serves the repeated attempt. Every output, including the stall line, comes straight from a flip-flop. The synchronous active-high reset clears only the bus-facing state and leaves the register contents in place.

Top module: `wb_regbank`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `wb_ack`, `wb_err` and `wb_rty` are low and `wb_rdat` is zero. `wb_stall` is high exactly when `cfg_stall_len` is non-zero.
- R2: The slave takes a transfer at the clock edge where `wb_cyc`, `wb_stb` are high and `wb_stall` is low. Its termination appears in the next cycle. For an in-range write the register changes at that accepting edge. For an in-range read the `wb_ack` cycle carries the register value on `wb_rdat`.
- R3: `wb_ack`, `wb_err` and `wb_rty` are never high together, and each pulse lasts one cycle. `wb_stall` is high during every response cycle, so at most one transfer is outstanding.
- R4: An address equal to or above `NUM_REGS` ends with `wb_err` instead of `wb_ack`, writes nothing, and leaves `wb_rdat` zero.
- R5: With `cfg_stall_len` = N, a request that is held steadily sees `wb_stall` high for exactly N cycles before the accepting edge. N = 0 means no stall.
- R6: With `cfg_retry_en` high, an accepted request that does not follow a retry is answered by `wb_rty` and has no effect on the registers. The next accepted request is served normally with `wb_ack` or `wb_err`. After that, the pattern starts again.
- R7: A strobe without `wb_cyc`, or `wb_cyc` without a strobe, produces no termination and writes nothing.
- R8: `wb_rdat` is zero in every cycle except a read acknowledge. This includes write acknowledges and error and retry cycles.
- R9: Reset does not change the register contents: a value written before reset reads back unchanged after it.
- R10: With `cfg_stall_len` = 0 and the request held, the slave takes a new transfer every second cycle: response cycle, then accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the bus state |
| wb_cyc | input | 1 | Bus cycle in progress |
| wb_stb | input | 1 | Transfer strobe qualifying address, data and write flag |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_adr | input | AW | Register index |
| wb_wdat | input | DW | Write data |
| wb_rdat | output | DW | Read data, valid during a read acknowledge |
| wb_ack | output | 1 | Normal termination |
| wb_err | output | 1 | Error termination (address out of range) |
| wb_rty | output | 1 | Retry termination |
| wb_stall | output | 1 | Slave cannot take a transfer this cycle |
| cfg_stall_len | input | SW | Stall cycles imposed before each accept |
| cfg_retry_en | input | 1 | Answer each fresh request with a retry first |

## Verification
The register function is first tried with directed patterns:
- A write to every register followed by a read of each, which separates register storage from the address decode.
- Addresses just past the bank, which must show the acknowledge/error split and the absence of writes.
- Strobes without a cycle (and the reverse), which must be told apart from real transfers.

Retry mode is tried as a write that must not land, a read that is served, and a second write that lands only on its repeat. This distinguishes a retry that is counted per request from one that is ignored or always repeated. Constrained random transfers then mix stall lengths 0 to 3, retry on and off, reads and writes, and in-range and out-of-range addresses. This checks stall counts, termination kind and data together against a bench model of the bank. A reset in the middle of the run shows that contents survive it.

// File: rtl/wb_regbank_pkg.sv
package wb_regbank_pkg;

    localparam int MAX_DW = 64;

    typedef enum logic {
        PH_IDLE,
        PH_RESP
    } phase_e;

    typedef enum logic [1:0] {
        TERM_ACK,
        TERM_ERR,
        TERM_RTY
    } term_e;

    // termination chosen for an accepted request
    function automatic term_e pick_term(input logic retry_en,
                                        input logic retried,
                                        input logic hit);
        if (retry_en && !retried) return TERM_RTY;
        if (hit)                  return TERM_ACK;
        return TERM_ERR;
    endfunction

    function automatic logic addr_hits(input logic [63:0] adr,
                                       input int unsigned count);
        return adr < 64'(count);
    endfunction

endpackage

// File: rtl/wbrb_store.sv
module wbrb_store #(
    parameter int NUM_REGS = 8,
    parameter int DW       = 32,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);

    logic [DW-1:0] cells [NUM_REGS];

    // contents are deliberately not reset
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (wr_en && (int'(wr_idx) == i)) begin
                cells[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < NUM_REGS) begin
            rd_data = cells[rd_idx];
        end
    end

endmodule

// File: rtl/wbrb_pacer.sv
module wbrb_pacer #(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          idle,
    input  logic          req,
    input  logic          accept,
    input  logic [SW-1:0] cfg_len,
    output logic          stall
);

    logic [SW-1:0] cnt_q;
    logic          stall_q;
    logic [SW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            stall_q <= (cfg_len != '0);
        end else if (accept) begin
            cnt_q   <= '0;
            stall_q <= 1'b1;
        end else if (!idle) begin
            cnt_q   <= '0;
            stall_q <= (cfg_len != '0);
        end else if (req && stall_q) begin
            cnt_q   <= cnt_inc[SW-1:0];
            stall_q <= (cnt_inc < {1'b0, cfg_len});
        end else begin
            stall_q <= (cnt_q < cfg_len);
        end
    end

    assign stall = stall_q;

    // R5: the stall line never drops in the cycle right after an accept
    p_hold_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
        accept |=> stall_q);

endmodule

// File: rtl/wb_regbank.sv
module wb_regbank
    import wb_regbank_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DW       = 32,
    parameter int AW       = 8,
    parameter int SW       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wb_cyc,
    input  logic          wb_stb,
    input  logic          wb_we,
    input  logic [AW-1:0] wb_adr,
    input  logic [DW-1:0] wb_wdat,
    output logic [DW-1:0] wb_rdat,
    output logic          wb_ack,
    output logic          wb_err,
    output logic          wb_rty,
    output logic          wb_stall,
    input  logic [SW-1:0] cfg_stall_len,
    input  logic          cfg_retry_en
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    phase_e        phase_q;
    logic          ack_q, err_q, rty_q, retried_q;
    logic [DW-1:0] rdat_q;
    logic          req, accept, hit, wr_en;
    term_e         term;
    logic [DW-1:0] rd_data;
    logic [IDX_W-1:0] idx;

    assign req    = wb_cyc && wb_stb;
    assign accept = req && !wb_stall && (phase_q == PH_IDLE);
    assign hit    = addr_hits(64'(wb_adr), NUM_REGS);
    assign term   = pick_term(cfg_retry_en, retried_q, hit);
    assign idx    = wb_adr[IDX_W-1:0];
    assign wr_en  = accept && wb_we && (term == TERM_ACK);

    wbrb_pacer #(.SW(SW)) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .idle    (phase_q == PH_IDLE),
        .req     (req),
        .accept  (accept),
        .cfg_len (cfg_stall_len),
        .stall   (wb_stall)
    );

    wbrb_store #(.NUM_REGS(NUM_REGS), .DW(DW), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (wb_wdat),
        .rd_idx  (idx),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            ack_q     <= 1'b0;
            err_q     <= 1'b0;
            rty_q     <= 1'b0;
            retried_q <= 1'b0;
            rdat_q    <= '0;
        end else begin
            ack_q  <= 1'b0;
            err_q  <= 1'b0;
            rty_q  <= 1'b0;
            rdat_q <= '0;
            if (accept) begin
                phase_q <= PH_RESP;
                case (term)
                    TERM_RTY: begin
                        rty_q     <= 1'b1;
                        retried_q <= 1'b1;
                    end
                    TERM_ACK: begin
                        ack_q     <= 1'b1;
                        retried_q <= 1'b0;
                        if (!wb_we) rdat_q <= rd_data;
                    end
                    default: begin
                        err_q     <= 1'b1;
                        retried_q <= 1'b0;
                    end
                endcase
            end else begin
                phase_q <= PH_IDLE;
            end
        end
    end

    assign wb_ack  = ack_q;
    assign wb_err  = err_q;
    assign wb_rty  = rty_q;
    assign wb_rdat = rdat_q;

    p_term_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wb_ack, wb_err, wb_rty}));

    p_term_single_r3: assert property (@(posedge clk) disable iff (rst)
        (wb_ack || wb_err || wb_rty) |=> !(wb_ack || wb_err || wb_rty));

    p_resp_stalls_r3: assert property (@(posedge clk) disable iff (rst)
        (wb_ack || wb_err || wb_rty) |-> wb_stall);

    // R7: a termination only follows a handshake on the previous edge
    p_resp_needs_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (wb_ack || wb_err || wb_rty) |-> $past(wb_cyc && wb_stb && !wb_stall));

    p_dat_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (wb_rdat != '0) |-> wb_ack);

endmodule

// File: tb/wb_regbank_bench.sv
module wb_regbank_bench;

    localparam int NUM_REGS = 8;
    localparam int DW       = 32;
    localparam int AW       = 8;
    localparam int SW       = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          wb_cyc, wb_stb, wb_we;
    logic [AW-1:0] wb_adr;
    logic [DW-1:0] wb_wdat, wb_rdat;
    logic          wb_ack, wb_err, wb_rty, wb_stall;
    logic [SW-1:0] cfg_stall_len;
    logic          cfg_retry_en;

    int checks   = 0;
    int failures = 0;

    logic [DW-1:0] model [NUM_REGS];
    logic          m_retried;

    always #4 clk = ~clk;

    wb_regbank #(.NUM_REGS(NUM_REGS), .DW(DW), .AW(AW), .SW(SW)) u_wb_regbank (
        .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_wdat(wb_wdat), .wb_rdat(wb_rdat), .wb_ack(wb_ack),
        .wb_err(wb_err), .wb_rty(wb_rty), .wb_stall(wb_stall),
        .cfg_stall_len(cfg_stall_len), .cfg_retry_en(cfg_retry_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected termination as {ack,err,rty}
    function automatic logic [2:0] exp_term(input logic ren, input logic [AW-1:0] adr);
        if (ren && !m_retried) return 3'b001;
        if (adr < AW'(NUM_REGS)) return 3'b100;
        return 3'b010;
    endfunction

    task automatic quiet_check(input string req);
        chk(req, {wb_ack, wb_err, wb_rty}, 3'b000);
    endtask

    // starts and ends on a negedge; inputs change only on negedges
    task automatic xfer(input logic we, input logic [AW-1:0] adr,
                        input logic [DW-1:0] d, input int len, input logic ren);
        int stalls;
        logic [2:0] et;
        logic [DW-1:0] ed;
        cfg_stall_len = SW'(len);
        cfg_retry_en  = ren;
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_adr = adr; wb_wdat = d;
        stalls = 0;
        while (wb_stall && stalls < 20) begin
            stalls++;
            @(negedge clk);
        end
        chk("R5 stall cycles", 64'(stalls), 64'(len));
        et = exp_term(ren, adr);
        ed = (et == 3'b100 && !we) ? model[adr[2:0]] : '0;
        @(negedge clk);
        if (et == 3'b001)      chk("R6 retry term", {wb_ack, wb_err, wb_rty}, et);
        else if (et == 3'b010) chk("R4 error term", {wb_ack, wb_err, wb_rty}, et);
        else                   chk("R2 ack term", {wb_ack, wb_err, wb_rty}, et);
        chk("R8 R2 read data", wb_rdat, ed);
        chk("R3 stall in response", wb_stall, 1'b1);
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
        if (et == 3'b001) m_retried = 1'b1;
        else begin
            m_retried = 1'b0;
            if (et == 3'b100 && we) model[adr[2:0]] = d;
        end
        @(negedge clk);
        quiet_check("R3 single cycle term");
    endtask

    task automatic do_reset(input int len);
        cfg_stall_len = SW'(len);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 terms in reset", {wb_ack, wb_err, wb_rty}, 3'b000);
        rst = 1'b0;
        m_retried = 1'b0;
        chk("R1 data after reset", wb_rdat, '0);
        chk("R1 stall after reset", wb_stall, (len != 0));
        @(negedge clk);
        chk("R1 terms after release", {wb_ack, wb_err, wb_rty}, 3'b000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        wb_cyc = 0; wb_stb = 0; wb_we = 0; wb_adr = '0; wb_wdat = '0;
        cfg_retry_en = 0; m_retried = 0;
        do_reset(2);
        do_reset(0);

        // R2: fill every register then read each back
        for (int i = 0; i < NUM_REGS; i++) xfer(1'b1, AW'(i), DW'(32'hA500 + i * 3), 0, 1'b0);
        for (int i = 0; i < NUM_REGS; i++) xfer(1'b0, AW'(i), '0, 0, 1'b0);

        // R4: out of range write and read; register 0 untouched
        xfer(1'b1, AW'(NUM_REGS), 32'hDEAD, 1, 1'b0);
        xfer(1'b0, AW'(NUM_REGS + 5), '0, 0, 1'b0);
        xfer(1'b0, AW'(0), '0, 0, 1'b0);

        // R6: retry refuses write once, then serves the read, then write lands on repeat
        xfer(1'b1, AW'(2), 32'h0000_00AA, 0, 1'b1);
        xfer(1'b0, AW'(2), '0, 0, 1'b1);
        xfer(1'b1, AW'(2), 32'h0000_00BB, 0, 1'b1);
        xfer(1'b1, AW'(2), 32'h0000_00BB, 0, 1'b1);
        xfer(1'b0, AW'(2), '0, 2, 1'b0);

        // R7: strobe without cycle and cycle without strobe
        cfg_stall_len = '0;
        @(negedge clk);
        wb_stb = 1; wb_we = 1; wb_adr = AW'(1); wb_wdat = 32'h1234_5678;
        repeat (3) begin @(negedge clk); quiet_check("R7 stb without cyc"); end
        wb_stb = 0; wb_cyc = 1;
        repeat (2) begin @(negedge clk); quiet_check("R7 cyc without stb"); end
        wb_cyc = 0; wb_we = 0;
        xfer(1'b0, AW'(1), '0, 0, 1'b0);

        // R10: back-to-back reads with request held
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = AW'(3);
        chk("R10 no stall at start", wb_stall, 1'b0);
        @(negedge clk);
        chk("R10 first ack", wb_ack, 1'b1);
        chk("R10 first data", wb_rdat, model[3]);
        wb_adr = AW'(4);
        @(negedge clk);
        chk("R10 free after response", {wb_ack, wb_stall}, 2'b00);
        @(negedge clk);
        chk("R10 second ack", wb_ack, 1'b1);
        chk("R10 second data", wb_rdat, model[4]);
        wb_cyc = 0; wb_stb = 0;
        @(negedge clk);

        // R9: reset keeps contents
        xfer(1'b1, AW'(5), 32'hCAFE_F00D, 0, 1'b0);
        do_reset(1);
        xfer(1'b0, AW'(5), '0, 1, 1'b0);

        // constrained random mix
        for (int n = 0; n < 200; n++) begin
            logic [AW-1:0] a;
            logic w, r;
            int l;
            a = AW'($urandom_range(NUM_REGS + 3, 0));
            w = 1'($urandom_range(1, 0));
            r = ($urandom_range(3, 0) == 0);
            l = $urandom_range(3, 0);
            xfer(w, a, $urandom(), l, r);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule